// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker with Block Zeroing

This block sits beside a load/store pipeline. It decides whether a cache-block operation may run, and for a permitted zero operation it writes the whole block. Each request carries the operation type, the current privilege level, a flag that says whether the hart runs virtualized, the relevant enable fields of the machine, hypervisor and supervisor environment-configuration registers, and an effective address.

The block answers one cycle later with two fault flags and the block-aligned address:

- One flag reports an illegal-instruction fault.
- The other flag reports a virtual-instruction fault.

The permission test works through three privilege layers. It reports only the first test that fails.

A zero operation that passes the test drives a stream of zero-byte stores. The stream covers every byte of the block in ascending address order, whatever kind of memory the address maps to. Each store waits for a ready/valid handshake, and a one-cycle completion pulse follows the last accepted byte. Clean, flush and invalidate operations produce only the permission answer.

Top module: `cbo_gate`

## Requirements
- R1: The operation code selects the enable bit that is tested in every configuration vector. The codes are 0 = zero, 1 = clean, 2 = flush and 3 = invalidate. Bit 0 of each vector enables zero, bit 1 enables both clean and flush, and bit 2 enables invalidate.
- R2: The privilege encoding is user = 0, supervisor = 1, machine = 3. When the privilege is below machine and the selected machine-level bit is clear, the illegal flag is raised.
- R3: The virtual flag is raised when all of the following hold:
  - the test in R2 passes;
  - virtualization is enabled;
  - either the privilege is supervisor or user and the selected hypervisor-level bit is clear, or the privilege is user and the selected supervisor-level bit is clear.
- R4: When neither R2 nor R3 fires, a user-level request whose selected supervisor-level bit is clear raises the illegal flag.
- R5: At most one fault flag is high at a time, and a request made at machine privilege never faults.
- R6: A request is accepted when req_valid_i and req_ready_o are both high. resp_valid_o pulses high in the next cycle with the flags and the block address. These values hold until the next response.
- R7: The block address is the effective address with its low log2(BLK_BYTES) bits cleared.
- R8: A permitted zero operation drives st_valid_o from the response cycle onward. Its addresses run from the block base upward by one per accepted handshake, and the address holds steady while st_ready_i is low.
- R9: Exactly BLK_BYTES stores are issued. done_o pulses for one cycle in the cycle after the last accepted store, and st_valid_o is low from that cycle on.
- R10: A faulted request, or any clean, flush or invalidate request, issues no store and no done pulse.
- R11: After reset req_ready_o is high and every other output is low. req_ready_o is low while a store stream is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block can accept a request |
| op_i | input | 2 | Operation code |
| priv_i | input | 2 | Current privilege level |
| virt_en_i | input | 1 | Virtualization enabled |
| m_en_i | input | 3 | Machine-level enable bits |
| h_en_i | input | 3 | Hypervisor-level enable bits |
| s_en_i | input | 3 | Supervisor-level enable bits |
| addr_i | input | ADDR_W | Effective address |
| resp_valid_o | output | 1 | Response pulse |
| ill_o | output | 1 | Illegal-instruction fault |
| virt_fault_o | output | 1 | Virtual-instruction fault |
| blk_addr_o | output | ADDR_W | Block-aligned address |
| st_valid_o | output | 1 | Zero-byte store valid |
| st_ready_i | input | 1 | Store accepted |
| st_addr_o | output | ADDR_W | Byte address of the zero store |
| done_o | output | 1 | Block zeroing complete |

## Verification
A wrong fault decision shows on ill_o or virt_fault_o in the response cycle right after the request. The sweep covers every operation, privilege, virtualization setting and enable-bit combination, so a wrong lookup or a wrong check order shows up at once.

A byte counter or base register that goes wrong shows as a skipped, repeated or out-of-range store address at the first affected handshake. A stream that ends early or late shows as a done_o pulse that is missing or misplaced, at most one block length later. A stray store after a fault or a non-zero operation is visible on st_valid_o in the response cycle.

// File: rtl/cbo_pkg.sv
package cbo_pkg;
  typedef enum logic [1:0] {
    OP_ZERO  = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_INVAL = 2'd3
  } cbo_op_e;

  typedef logic [1:0] priv_t;
  localparam priv_t PRIV_U = 2'd0;
  localparam priv_t PRIV_S = 2'd1;
  localparam priv_t PRIV_M = 2'd3;

  localparam int EN_W    = 3;
  localparam int EN_ZERO = 0;
  localparam int EN_CF   = 1;
  localparam int EN_INV  = 2;

  localparam int LVL_N = 3;
  localparam int LVL_M = 0;
  localparam int LVL_H = 1;
  localparam int LVL_S = 2;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_ILL  = 2'd1,
    FLT_VIRT = 2'd2
  } fault_e;
endpackage

// File: rtl/cbo_perm.sv
module cbo_perm
  import cbo_pkg::*;
(
  input  cbo_op_e         op_i,
  input  priv_t           priv_i,
  input  logic            virt_en_i,
  input  logic [EN_W-1:0] m_en_i,
  input  logic [EN_W-1:0] h_en_i,
  input  logic [EN_W-1:0] s_en_i,
  output fault_e          fault_o
);
  logic [EN_W-1:0]             sel_oh;
  logic [LVL_N-1:0][EN_W-1:0]  lvl_en;
  logic [LVL_N-1:0]            lvl_ok;
  logic below_m, upto_s, below_s;

  always_comb begin
    sel_oh = '0;
    unique case (op_i)
      OP_ZERO:           sel_oh[EN_ZERO] = 1'b1;
      OP_CLEAN, OP_FLUSH: sel_oh[EN_CF]  = 1'b1;
      default:           sel_oh[EN_INV]  = 1'b1;
    endcase
  end

  always_comb begin
    lvl_en[LVL_M] = m_en_i;
    lvl_en[LVL_H] = h_en_i;
    lvl_en[LVL_S] = s_en_i;
  end

  for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
    assign lvl_ok[g] = |(lvl_en[g] & sel_oh);
  end

  assign below_m = (priv_i != PRIV_M);
  assign upto_s  = (priv_i == PRIV_U) || (priv_i == PRIV_S);
  assign below_s = (priv_i == PRIV_U);

  // fixed order: machine gate, then virtual gate, then supervisor gate
  always_comb begin
    if (below_m && !lvl_ok[LVL_M])
      fault_o = FLT_ILL;
    else if (virt_en_i && ((upto_s && !lvl_ok[LVL_H]) || (below_s && !lvl_ok[LVL_S])))
      fault_o = FLT_VIRT;
    else if (below_s && !lvl_ok[LVL_S])
      fault_o = FLT_ILL;
    else
      fault_o = FLT_NONE;
  end
endmodule

// File: rtl/cbo_align.sv
module cbo_align #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  localparam int OFF_W = $clog2(BLK_BYTES);

  assign base_o = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/cbo_zero_seq.sv
module cbo_zero_seq #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              busy_o,
  output logic              st_valid_o,
  input  logic              st_ready_i,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic              done_o
);
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic             busy_q, done_q;
  logic [OFF_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  logic             fire, last;

  assign fire = busy_q && st_ready_i;
  assign last = (idx_q == OFF_W'(BLK_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      tag_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        tag_q  <= base_i[ADDR_W-1:OFF_W];
      end else if (fire) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign st_valid_o = busy_q;
  assign st_addr_o  = {tag_q, idx_q};
  assign done_o     = done_q;
endmodule

// File: rtl/cbo_gate.sv
module cbo_gate
  import cbo_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        op_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_en_i,
  input  logic [2:0]        m_en_i,
  input  logic [2:0]        h_en_i,
  input  logic [2:0]        s_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              resp_valid_o,
  output logic              ill_o,
  output logic              virt_fault_o,
  output logic [ADDR_W-1:0] blk_addr_o,
  output logic              st_valid_o,
  input  logic              st_ready_i,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic              done_o
);
  fault_e            fault;
  cbo_op_e           op;
  logic [ADDR_W-1:0] base;
  logic              busy, accept, start;
  logic              resp_q, ill_q, virt_q;
  logic [ADDR_W-1:0] blk_q;

  assign op = cbo_op_e'(op_i);

  cbo_perm u_perm (
    .op_i      (op),
    .priv_i    (priv_i),
    .virt_en_i (virt_en_i),
    .m_en_i    (m_en_i),
    .h_en_i    (h_en_i),
    .s_en_i    (s_en_i),
    .fault_o   (fault)
  );

  cbo_align #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_align (
    .addr_i (addr_i),
    .base_o (base)
  );

  assign req_ready_o = !busy;
  assign accept      = req_valid_i && req_ready_o;
  assign start       = accept && (op == OP_ZERO) && (fault == FLT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q <= 1'b0;
      ill_q  <= 1'b0;
      virt_q <= 1'b0;
      blk_q  <= '0;
    end else begin
      resp_q <= accept;
      if (accept) begin
        ill_q  <= (fault == FLT_ILL);
        virt_q <= (fault == FLT_VIRT);
        blk_q  <= base;
      end
    end
  end

  cbo_zero_seq #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .base_i     (base),
    .busy_o     (busy),
    .st_valid_o (st_valid_o),
    .st_ready_i (st_ready_i),
    .st_addr_o  (st_addr_o),
    .done_o     (done_o)
  );

  assign resp_valid_o = resp_q;
  assign ill_o        = ill_q;
  assign virt_fault_o = virt_q;
  assign blk_addr_o   = blk_q;
endmodule

// File: rtl/cbo_gate_chk.sv
module cbo_gate_chk #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        op_i,
  input logic [1:0]        priv_i,
  input logic [2:0]        m_en_i,
  input logic              resp_valid_o,
  input logic              ill_o,
  input logic              virt_fault_o,
  input logic [ADDR_W-1:0] blk_addr_o,
  input logic              st_valid_o,
  input logic              st_ready_i,
  input logic [ADDR_W-1:0] st_addr_o,
  input logic              done_o
);
  localparam int OFF_W = $clog2(BLK_BYTES);

  logic acc;
  logic m_bit;
  logic st_last;

  assign acc     = req_valid_i && req_ready_o;
  assign m_bit   = (op_i == 2'd0) ? m_en_i[0] : (op_i == 2'd3) ? m_en_i[2] : m_en_i[1];
  assign st_last = &st_addr_o[OFF_W-1:0];

  AST_ONE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ill_o && virt_fault_o)); // R5
  AST_MACH_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && priv_i == 2'd3 |=> !ill_o && !virt_fault_o); // R5
  AST_MACH_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && priv_i != 2'd3 && !m_bit |=> ill_o); // R2
  AST_RESP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> resp_valid_o); // R6
  AST_BLK_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> blk_addr_o[OFF_W-1:0] == '0); // R7
  AST_ST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_o && !st_ready_i |=> st_valid_o && $stable(st_addr_o)); // R8
  AST_ST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_o && st_ready_i && !st_last |=> st_valid_o && st_addr_o == $past(st_addr_o) + 1'b1); // R8
  AST_ST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_o && st_ready_i && st_last |=> done_o && !st_valid_o); // R9
  AST_FAULT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && (ill_o || virt_fault_o) |-> !st_valid_o); // R10
  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_o |-> !req_ready_o); // R11
endmodule

bind cbo_gate cbo_gate_chk #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .op_i         (op_i),
  .priv_i       (priv_i),
  .m_en_i       (m_en_i),
  .resp_valid_o (resp_valid_o),
  .ill_o        (ill_o),
  .virt_fault_o (virt_fault_o),
  .blk_addr_o   (blk_addr_o),
  .st_valid_o   (st_valid_o),
  .st_ready_i   (st_ready_i),
  .st_addr_o    (st_addr_o),
  .done_o       (done_o)
);

// File: tb/cbo_gate_bench.sv
`timescale 1ns/1ps
module cbo_gate_bench;
  localparam int AW  = 32;
  localparam int BLK = 8;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    op = '0;
  logic [1:0]    priv = '0;
  logic          virt = 1'b0;
  logic [2:0]    m_en = '0, h_en = '0, s_en = '0;
  logic [AW-1:0] addr = '0;
  logic          resp_valid, ill, vflt, st_valid, done;
  logic          st_ready = 1'b0;
  logic [AW-1:0] blk_addr, st_addr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int tick   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cbo_gate #(.ADDR_W(AW), .BLK_BYTES(BLK)) u_cbo_gate (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .op_i(op), .priv_i(priv), .virt_en_i(virt), .m_en_i(m_en), .h_en_i(h_en),
    .s_en_i(s_en), .addr_i(addr), .resp_valid_o(resp_valid), .ill_o(ill),
    .virt_fault_o(vflt), .blk_addr_o(blk_addr), .st_valid_o(st_valid),
    .st_ready_i(st_ready), .st_addr_o(st_addr), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 none, 1 illegal, 2 virtual
  function automatic int exp_fault(int o, int p, int v, int m, int h, int s);
    int b;
    bit mb, hb, sb;
    b  = (o == 0) ? 0 : (o == 3) ? 2 : 1; // R1
    mb = m[b]; hb = h[b]; sb = s[b];
    if (p != 3 && !mb) return 1;                                  // R2
    if (v != 0 && ((p <= 1 && !hb) || (p == 0 && !sb))) return 2; // R3
    if (p == 0 && !sb) return 1;                                  // R4
    return 0;
  endfunction

  task automatic do_req(input int o, input int p, input int v, input int m,
                        input int h, input int s, input logic [AW-1:0] a);
    int f;
    logic [AW-1:0] base;
    f    = exp_fault(o, p, v, m, h, s);
    base = a & ~AW'(BLK - 1);
    chk(req_ready == 1'b1, "R11 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; op = 2'(o); priv = 2'(p); virt = 1'(v);
    m_en = 3'(m); h_en = 3'(h); s_en = 3'(s); addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid == 1'b1, "R6 response pulse", 64'(resp_valid), 64'd1);
    chk(ill == (f == 1), "R2 R4 illegal flag", 64'(ill), 64'(f == 1));
    chk(vflt == (f == 2), "R3 virtual flag", 64'(vflt), 64'(f == 2));
    chk(blk_addr == base, "R7 block address", 64'(blk_addr), 64'(base));
    if (o == 0 && f == 0) begin
      int k = 0;
      while (k < BLK) begin
        st_ready = ((tick % 3) != 1);
        tick++;
        chk(st_valid == 1'b1, "R8 store valid", 64'(st_valid), 64'd1);
        if (!st_valid) break;
        chk(st_addr == base + AW'(k), "R8 store address", 64'(st_addr), 64'(base + AW'(k)));
        chk(req_ready == 1'b0, "R11 busy blocks request", 64'(req_ready), 64'd0);
        chk(done == 1'b0, "R9 no early done", 64'(done), 64'd0);
        if (st_ready) k++;
        @(negedge clk);
      end
      st_ready = 1'b0;
      chk(done == 1'b1, "R9 done pulse", 64'(done), 64'd1);
      chk(st_valid == 1'b0, "R9 stream ended", 64'(st_valid), 64'd0);
      @(negedge clk);
      chk(done == 1'b0, "R9 done one cycle", 64'(done), 64'd0);
    end else begin
      chk(st_valid == 1'b0, "R10 no store", 64'(st_valid), 64'd0);
      chk(done == 1'b0, "R10 no done", 64'(done), 64'd0);
      if (f != 0) chk(!(ill && vflt), "R5 single fault", 64'({ill, vflt}), 64'd0);
      if (p == 3) chk(f == 0 && !ill && !vflt, "R5 machine never faults", 64'({ill, vflt}), 64'd0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n = 0;
    int pv[3] = '{0, 1, 3};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11 reset ready", 64'(req_ready), 64'd1);
    chk(resp_valid == 1'b0 && ill == 1'b0 && vflt == 1'b0, "R11 reset flags",
        64'({resp_valid, ill, vflt}), 64'd0);
    chk(st_valid == 1'b0 && done == 1'b0, "R11 reset stream", 64'({st_valid, done}), 64'd0);
    chk(blk_addr == '0, "R11 reset address", 64'(blk_addr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int o = 0; o < 4; o++)
      for (int pi = 0; pi < 3; pi++)
        for (int v = 0; v < 2; v++)
          for (int m = 0; m < 8; m++)
            for (int h = 0; h < 8; h++)
              for (int s = 0; s < 8; s++) begin
                n++;
                do_req(o, pv[pi], v, m, h, s, AW'(n) * 32'h9E37_79B9 + AW'(n));
              end
    // R7 boundary addresses with a full zero stream
    do_req(0, 3, 0, 0, 0, 0, 32'hFFFF_FFFF);
    do_req(0, 3, 0, 0, 0, 0, 32'h0000_0000);
    do_req(0, 1, 1, 7, 7, 0, 32'h1234_5677);
    // R6 flags hold after the response pulse
    do_req(3, 0, 0, 0, 7, 7, 32'h40);
    @(negedge clk);
    chk(resp_valid == 1'b0, "R6 pulse ends", 64'(resp_valid), 64'd0);
    chk(ill == 1'b1, "R6 flag holds", 64'(ill), 64'd1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule